// File: doc/BRIEF.md
# Multi-rail power sequencing controller

This block is the digital supervisor that brings up to three supply rails up and down through external pass switches. It works only on digital flags produced by comparators elsewhere: a per-rail undervoltage-lockout result, an enable-above-threshold flag, an internal-supply-valid flag, per-rail power-good and power-low flags on the switched outputs, and a tracking-error flag from the separate ramp generator. From these it drives per-rail gate enables, per-rail fast-discharge pulldown enables, an active-low fault output, a power-good output and a two-bit command to the ramp generator.

Bring-up is either ramp-tracked (all rails follow one ramp together) or sequential (rail 1, then rail 2, then rail 3, each after its own start delay). Shutdown on a falling enable is always a common tracked ramp-down. Faults and slow bring-up turn every gate off and every pulldown on. Recovery is either automatic after a long hold-off or latched until the enable is cycled, and a new attempt always waits until every output is discharged. Delay, fault, power-good and retry windows are cycle counts taken from parameters.

Top module: `pwr_rail_seq`

## Requirements
- R1: After reset all gate and pulldown enables are 0, fault_n is 1, ramp_cmd is 00 (hold) and pwr_good is 0.
- R2: Power-up starts only when vint_ok, en_hi and every uvlo_ok bit are 1 and every controlled output reports power-low; no gate turns on until DELAY_CYC cycles have passed in the start delay, so the first gate rises DELAY_CYC+1 cycles after the start condition is first seen, and a loss of the start condition during that delay returns to idle with no gate enabled.
- R3: When mode_pin was 0 (tracking) at the start, all controlled gates turn on together with ramp_cmd 01 (up) until every controlled rail reports power-good.
- R4: When mode_pin was 1 (sequence) at the start, rail i+1's gate turns on only after rail i reports power-good and a further start delay, i.e. DELAY_CYC+1 cycles later; ramp_cmd is 01 while a rail is ramping.
- R5: Once all controlled rails report power-good, pwr_good rises PGTO_CYC+1 cycles later.
- R6: A start condition lost while pwr_good is 1 starts a common ramp-down: every controlled gate stays on, ramp_cmd is 10 (down), no pulldown is on, and all gates turn off in the cycle after every output reports power-low.
- R7: A start condition lost after a gate is on but before pwr_good rises turns all gates off and all pulldowns on with fault_n still 1, until all outputs report power-low.
- R8: A tracking error while ramping, a power-good loss while gates are fully on, or bring-up of a rail lasting FAULT_CYC cycles turns all gates off, all controlled pulldowns on and drives fault_n to 0.
- R9: With retry_pin 1 (autoretry) at the start, fault_n returns to 1 after a hold of 16*FAULT_CYC cycles followed by a start condition with all outputs at power-low, and a fresh start delay follows.
- R10: With retry_pin 0 (latch), the fault persists until en_hi has gone low and then high again; a full retry hold then passes before the next attempt.
- R11: vint_ok low in any active state turns all gates off and pulldowns on with fault_n 1 (clearing a held fault), and the controller returns to idle once the outputs are discharged.
- R12: A rail with rail_present 0 never has its gate or pulldown enabled and its power-good and power-low flags are ignored.
- R13: mode_pin and retry_pin pass a two-flop synchronizer and are read only when leaving idle; changes at any other time have no effect on the attempt in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rail_present | input | NUM_RAILS | 1 = rail is controlled, 0 = excluded |
| uvlo_ok | input | NUM_RAILS | Input supply above its lockout threshold |
| en_hi | input | 1 | Enable above its threshold |
| vint_ok | input | 1 | Internal supply valid |
| out_pg | input | NUM_RAILS | Output above power-good fraction of its input |
| out_pl | input | NUM_RAILS | Output below power-low level |
| trk_fault | input | 1 | Output outside the tracking window of the ramp |
| mode_pin | input | 1 | 0 = tracking, 1 = sequence |
| retry_pin | input | 1 | 0 = latch-off, 1 = autoretry |
| gate_en | output | NUM_RAILS | Pass-switch gate enable |
| pd_en | output | NUM_RAILS | Fast-discharge pulldown enable |
| fault_n | output | 1 | Fault, active low |
| ramp_cmd | output | 2 | 00 hold, 01 up, 10 down |
| pwr_good | output | 1 | All rails up and power-good timeout complete |

## Verification
The hardest situation to reach is the latched fault that is released only by an enable cycle and then still waits a full retry hold, because it needs a fault first and a retry-mode pin value that was sampled in an earlier idle period. The stimulus gets there by first driving the controller into an autoretry hold, changing the pin values there (which must be ignored), dropping the internal supply to force a return to idle so the new values are sampled, and then provoking a tracking error. A behavioural reference model of the state sequence is compared with every output on each clock while directed checks time the delay, fault, power-good and retry windows.

// File: rtl/pwr_rail_seq_pkg.sv
`timescale 1ns/1ps
package pwr_rail_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_DLY     = 4'd1,
        ST_RAMP_UP = 4'd2,
        ST_SEQ_ON  = 4'd3,
        ST_PGWAIT  = 4'd4,
        ST_ON      = 4'd5,
        ST_RAMP_DN = 4'd6,
        ST_LATCH_A = 4'd7,
        ST_LATCH_B = 4'd8,
        ST_HOLD    = 4'd9,
        ST_RWAIT   = 4'd10,
        ST_SHUTDN  = 4'd11
    } seq_state_e;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'b00,
        RAMP_UP   = 2'b01,
        RAMP_DOWN = 2'b10
    } ramp_cmd_e;

endpackage

// File: rtl/pwr_rail_seq_sync.sv
`timescale 1ns/1ps
module pwr_rail_seq_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/pwr_rail_seq_rails.sv
`timescale 1ns/1ps
module pwr_rail_seq_rails
    import pwr_rail_seq_pkg::*;
#(
    parameter int NUM_RAILS = 3,
    parameter int IDX_W     = 2
) (
    input  seq_state_e           state,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_RAILS-1:0] present,
    input  logic [NUM_RAILS-1:0] out_pg,
    input  logic [NUM_RAILS-1:0] out_pl,
    output logic [NUM_RAILS-1:0] pg_eff,
    output logic [NUM_RAILS-1:0] pl_eff,
    output logic [NUM_RAILS-1:0] gate_en,
    output logic [NUM_RAILS-1:0] pd_en
);
    logic full_on;
    logic discharge;
    logic in_seq;

    assign full_on   = (state == ST_RAMP_UP) || (state == ST_PGWAIT) ||
                       (state == ST_ON)      || (state == ST_RAMP_DN);
    assign discharge = (state == ST_LATCH_A) || (state == ST_LATCH_B) ||
                       (state == ST_HOLD)    || (state == ST_RWAIT)   ||
                       (state == ST_SHUTDN);
    assign in_seq    = (state == ST_DLY) || (state == ST_SEQ_ON);

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
        localparam logic [IDX_W-1:0] RAIL_IDX = IDX_W'(i);
        logic done_rail;
        logic ramp_rail;

        // earlier rails of a sequence stay on; the current one only while ramping
        assign done_rail = in_seq && (RAIL_IDX < idx);
        assign ramp_rail = (state == ST_SEQ_ON) && (RAIL_IDX == idx);

        assign pg_eff[i]  = out_pg[i] | ~present[i];
        assign pl_eff[i]  = out_pl[i] | ~present[i];
        assign gate_en[i] = present[i] & (full_on | done_rail | ramp_rail);
        assign pd_en[i]   = present[i] & discharge;
    end
endmodule

// File: rtl/pwr_rail_seq_fsm.sv
`timescale 1ns/1ps
module pwr_rail_seq_fsm
    import pwr_rail_seq_pkg::*;
#(
    parameter int NUM_RAILS  = 3,
    parameter int IDX_W      = 2,
    parameter int DELAY_CYC  = 20000,
    parameter int FAULT_CYC  = 50000,
    parameter int PGTO_CYC   = 20000,
    parameter int RETRY_MULT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] uvlo_ok,
    input  logic                 en_hi,
    input  logic                 vint_ok,
    input  logic [NUM_RAILS-1:0] pg_eff,
    input  logic [NUM_RAILS-1:0] pl_eff,
    input  logic                 trk_fault,
    input  logic                 mode_s,
    input  logic                 retry_s,
    output seq_state_e           state,
    output logic [IDX_W-1:0]     idx,
    output logic                 fault_n,
    output logic [1:0]           ramp_cmd,
    output logic                 pwr_good
);
    localparam int RETRY_CYC = RETRY_MULT * FAULT_CYC;
    localparam int MAX_A     = (DELAY_CYC > FAULT_CYC) ? DELAY_CYC : FAULT_CYC;
    localparam int MAX_B     = (PGTO_CYC > RETRY_CYC) ? PGTO_CYC : RETRY_CYC;
    localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] DLY_LAST   = CNT_W'(DELAY_CYC - 1);
    localparam logic [CNT_W-1:0] FLT_LAST   = CNT_W'(FAULT_CYC - 1);
    localparam logic [CNT_W-1:0] PGTO_LAST  = CNT_W'(PGTO_CYC - 1);
    localparam logic [CNT_W-1:0] RETRY_LAST = CNT_W'(RETRY_CYC - 1);
    localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(NUM_RAILS - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic             seq;
        logic             rty;
    } regs_t;

    regs_t r_q, r_d;

    logic start_ok, go, all_pg, all_pl, cur_pg;

    assign start_ok = vint_ok & en_hi & (&uvlo_ok);
    assign all_pg   = &pg_eff;
    assign all_pl   = &pl_eff;
    assign go       = start_ok & all_pl;
    assign cur_pg   = pg_eff[r_q.idx];

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (go) begin
                    r_d.st  = ST_DLY;
                    r_d.idx = '0;
                    r_d.cnt = '0;
                    r_d.seq = mode_s;
                    r_d.rty = retry_s;
                end
            end
            ST_DLY: begin
                if (!start_ok) begin
                    r_d.st = (r_q.idx == '0) ? ST_IDLE : ST_SHUTDN;
                end else if (r_q.cnt == DLY_LAST) begin
                    r_d.st  = r_q.seq ? ST_SEQ_ON : ST_RAMP_UP;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_RAMP_UP: begin
                if (!start_ok) begin
                    r_d.st = ST_SHUTDN;
                end else if (trk_fault || (!all_pg && r_q.cnt == FLT_LAST)) begin
                    r_d.st  = r_q.rty ? ST_HOLD : ST_LATCH_A;
                    r_d.cnt = '0;
                end else if (all_pg) begin
                    r_d.st  = ST_PGWAIT;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_SEQ_ON: begin
                if (!start_ok) begin
                    r_d.st = ST_SHUTDN;
                end else if (cur_pg) begin
                    r_d.cnt = '0;
                    if (r_q.idx == IDX_LAST) begin
                        r_d.st = ST_PGWAIT;
                    end else begin
                        r_d.st  = ST_DLY;
                        r_d.idx = r_q.idx + IDX_W'(1);
                    end
                end else if (r_q.cnt == FLT_LAST) begin
                    r_d.st  = r_q.rty ? ST_HOLD : ST_LATCH_A;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_PGWAIT: begin
                if (!start_ok) begin
                    r_d.st = ST_SHUTDN;
                end else if (!all_pg) begin
                    r_d.st  = r_q.rty ? ST_HOLD : ST_LATCH_A;
                    r_d.cnt = '0;
                end else if (r_q.cnt == PGTO_LAST) begin
                    r_d.st = ST_ON;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_ON: begin
                if (!start_ok) begin
                    r_d.st = ST_RAMP_DN;
                end else if (!all_pg) begin
                    r_d.st  = r_q.rty ? ST_HOLD : ST_LATCH_A;
                    r_d.cnt = '0;
                end
            end
            ST_RAMP_DN: begin
                if (trk_fault) begin
                    r_d.st  = r_q.rty ? ST_HOLD : ST_LATCH_A;
                    r_d.cnt = '0;
                end else if (all_pl) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_LATCH_A: begin
                if (!en_hi) r_d.st = ST_LATCH_B;
            end
            ST_LATCH_B: begin
                if (en_hi) begin
                    r_d.st  = ST_HOLD;
                    r_d.cnt = '0;
                end
            end
            ST_HOLD: begin
                if (r_q.cnt == RETRY_LAST) begin
                    r_d.st = ST_RWAIT;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_RWAIT: begin
                if (go) begin
                    r_d.st  = ST_DLY;
                    r_d.idx = '0;
                    r_d.cnt = '0;
                end
            end
            ST_SHUTDN: begin
                if (all_pl) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase

        // loss of the internal supply overrides every active state
        if (!vint_ok && r_q.st != ST_IDLE && r_q.st != ST_SHUTDN) begin
            r_d.st = ST_SHUTDN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, idx: '0, cnt: '0, seq: 1'b0, rty: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state    = r_q.st;
    assign idx      = r_q.idx;
    assign fault_n  = !((r_q.st == ST_LATCH_A) || (r_q.st == ST_LATCH_B) ||
                        (r_q.st == ST_HOLD)    || (r_q.st == ST_RWAIT));
    assign pwr_good = (r_q.st == ST_ON);

    always_comb begin
        case (r_q.st)
            ST_RAMP_UP, ST_SEQ_ON: ramp_cmd = RAMP_UP;
            ST_RAMP_DN:            ramp_cmd = RAMP_DOWN;
            default:               ramp_cmd = RAMP_HOLD;
        endcase
    end
endmodule

// File: rtl/pwr_rail_seq.sv
`timescale 1ns/1ps
module pwr_rail_seq
    import pwr_rail_seq_pkg::*;
#(
    parameter int NUM_RAILS  = 3,
    parameter int DELAY_CYC  = 20000,
    parameter int FAULT_CYC  = 50000,
    parameter int PGTO_CYC   = 20000,
    parameter int RETRY_MULT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] rail_present,
    input  logic [NUM_RAILS-1:0] uvlo_ok,
    input  logic                 en_hi,
    input  logic                 vint_ok,
    input  logic [NUM_RAILS-1:0] out_pg,
    input  logic [NUM_RAILS-1:0] out_pl,
    input  logic                 trk_fault,
    input  logic                 mode_pin,
    input  logic                 retry_pin,
    output logic [NUM_RAILS-1:0] gate_en,
    output logic [NUM_RAILS-1:0] pd_en,
    output logic                 fault_n,
    output logic [1:0]           ramp_cmd,
    output logic                 pwr_good
);
    localparam int IDX_W = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1;

    logic [1:0]           pins_s;
    seq_state_e           state;
    logic [IDX_W-1:0]     idx;
    logic [NUM_RAILS-1:0] pg_eff, pl_eff;

    pwr_rail_seq_sync #(.WIDTH(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({mode_pin, retry_pin}),
        .dout (pins_s)
    );

    pwr_rail_seq_fsm #(
        .NUM_RAILS (NUM_RAILS),
        .IDX_W     (IDX_W),
        .DELAY_CYC (DELAY_CYC),
        .FAULT_CYC (FAULT_CYC),
        .PGTO_CYC  (PGTO_CYC),
        .RETRY_MULT(RETRY_MULT)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .uvlo_ok  (uvlo_ok),
        .en_hi    (en_hi),
        .vint_ok  (vint_ok),
        .pg_eff   (pg_eff),
        .pl_eff   (pl_eff),
        .trk_fault(trk_fault),
        .mode_s   (pins_s[1]),
        .retry_s  (pins_s[0]),
        .state    (state),
        .idx      (idx),
        .fault_n  (fault_n),
        .ramp_cmd (ramp_cmd),
        .pwr_good (pwr_good)
    );

    pwr_rail_seq_rails #(
        .NUM_RAILS(NUM_RAILS),
        .IDX_W    (IDX_W)
    ) u_rails (
        .state  (state),
        .idx    (idx),
        .present(rail_present),
        .out_pg (out_pg),
        .out_pl (out_pl),
        .pg_eff (pg_eff),
        .pl_eff (pl_eff),
        .gate_en(gate_en),
        .pd_en  (pd_en)
    );
endmodule

// File: rtl/pwr_rail_seq_chk.sv
`timescale 1ns/1ps
module pwr_rail_seq_chk #(
    parameter int NUM_RAILS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_RAILS-1:0] rail_present,
    input logic [NUM_RAILS-1:0] uvlo_ok,
    input logic                 en_hi,
    input logic                 vint_ok,
    input logic [NUM_RAILS-1:0] gate_en,
    input logic [NUM_RAILS-1:0] pd_en,
    input logic                 fault_n,
    input logic [1:0]           ramp_cmd,
    input logic                 pwr_good
);
    // R8: a held fault keeps every gate off and every controlled pulldown on
    a_r8_fault_discharge: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (gate_en == '0) && (pd_en == rail_present));

    // R8: gate and pulldown of a rail are never on together
    a_r8_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en & pd_en) == '0);

    // R6: ramp-down keeps all controlled gates on without pulldowns
    a_r6_dn_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_cmd == 2'b10) |-> (gate_en == rail_present) && (pd_en == '0));

    // R5: power good only with every controlled gate on
    a_r5_pg_gates: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_good |-> (gate_en == rail_present) && fault_n);

    // R12: excluded rails are never driven
    a_r12_excluded: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_en | pd_en) & ~rail_present) == '0);

    // R2: a first gate turn-on follows a valid start condition
    a_r2_start_ok: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(|gate_en) |-> $past(en_hi) && $past(vint_ok) && $past(&uvlo_ok)));

    // R11: loss of the internal supply turns every gate off next cycle
    a_r11_vint_off: assert property (@(posedge clk) disable iff (!rst_n)
        !vint_ok |=> (gate_en == '0));

    // R4: a gate is on only if the preceding controlled rail's gate is on
    for (genvar i = 1; i < NUM_RAILS; i++) begin : g_order
        a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_en[i] && rail_present[i-1]) |-> gate_en[i-1]);
    end
endmodule

bind pwr_rail_seq pwr_rail_seq_chk #(.NUM_RAILS(NUM_RAILS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rail_present(rail_present),
    .uvlo_ok     (uvlo_ok),
    .en_hi       (en_hi),
    .vint_ok     (vint_ok),
    .gate_en     (gate_en),
    .pd_en       (pd_en),
    .fault_n     (fault_n),
    .ramp_cmd    (ramp_cmd),
    .pwr_good    (pwr_good)
);

// File: tb/pwr_rail_seq_bench.sv
`timescale 1ns/1ps
module pwr_rail_seq_bench;
    localparam int DLY  = 5;
    localparam int FLT  = 30;
    localparam int PGTO = 4;
    localparam int RTY  = 16 * FLT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rail_present = 3'b111;
    logic [2:0] uvlo_ok = 3'b000;
    logic       en_hi = 1'b0;
    logic       vint_ok = 1'b0;
    logic [2:0] out_pg = 3'b000;
    logic [2:0] out_pl = 3'b111;
    logic       trk_fault = 1'b0;
    logic       mode_pin = 1'b0;
    logic       retry_pin = 1'b1;
    logic [2:0] gate_en, pd_en;
    logic       fault_n, pwr_good;
    logic [1:0] ramp_cmd;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    pwr_rail_seq #(
        .NUM_RAILS(3), .DELAY_CYC(DLY), .FAULT_CYC(FLT),
        .PGTO_CYC(PGTO), .RETRY_MULT(16)
    ) u_pwr_rail_seq (
        .clk(clk), .rst_n(rst_n), .rail_present(rail_present), .uvlo_ok(uvlo_ok),
        .en_hi(en_hi), .vint_ok(vint_ok), .out_pg(out_pg), .out_pl(out_pl),
        .trk_fault(trk_fault), .mode_pin(mode_pin), .retry_pin(retry_pin),
        .gate_en(gate_en), .pd_en(pd_en), .fault_n(fault_n),
        .ramp_cmd(ramp_cmd), .pwr_good(pwr_good)
    );

    // ---------------- behavioural reference model ----------------
    localparam int P_IDLE = 0, P_DLY = 1, P_UP = 2, P_SON = 3, P_PGW = 4, P_ON = 5;
    localparam int P_DN = 6, P_LA = 7, P_LB = 8, P_HOLD = 9, P_RW = 10, P_SD = 11;

    int       m_st, m_idx, m_cnt, ns;
    bit       m_seq, m_rty;
    bit [1:0] sy1, sy2;
    bit       pga, pla, sok, go, flt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = P_IDLE; m_idx = 0; m_cnt = 0; m_seq = 0; m_rty = 0;
            sy1 = 2'b00; sy2 = 2'b00;
        end else begin
            pga = &(out_pg | ~rail_present);
            pla = &(out_pl | ~rail_present);
            sok = vint_ok && en_hi && (&uvlo_ok);
            go  = sok && pla;
            flt = 1'b0;
            ns  = m_st;
            if (m_st == P_IDLE) begin
                if (go) begin ns = P_DLY; m_idx = 0; m_cnt = 0; m_seq = sy2[1]; m_rty = sy2[0]; end
            end else if (m_st == P_DLY) begin
                if (!sok) ns = (m_idx == 0) ? P_IDLE : P_SD;
                else if (m_cnt == DLY - 1) begin ns = m_seq ? P_SON : P_UP; m_cnt = 0; end
                else m_cnt++;
            end else if (m_st == P_UP) begin
                if (!sok) ns = P_SD;
                else if (trk_fault || (!pga && m_cnt == FLT - 1)) flt = 1'b1;
                else if (pga) begin ns = P_PGW; m_cnt = 0; end
                else m_cnt++;
            end else if (m_st == P_SON) begin
                if (!sok) ns = P_SD;
                else if (out_pg[m_idx] || !rail_present[m_idx]) begin
                    m_cnt = 0;
                    if (m_idx == 2) ns = P_PGW;
                    else begin ns = P_DLY; m_idx++; end
                end else if (m_cnt == FLT - 1) flt = 1'b1;
                else m_cnt++;
            end else if (m_st == P_PGW) begin
                if (!sok) ns = P_SD;
                else if (!pga) flt = 1'b1;
                else if (m_cnt == PGTO - 1) ns = P_ON;
                else m_cnt++;
            end else if (m_st == P_ON) begin
                if (!sok) ns = P_DN;
                else if (!pga) flt = 1'b1;
            end else if (m_st == P_DN) begin
                if (trk_fault) flt = 1'b1;
                else if (pla) ns = P_IDLE;
            end else if (m_st == P_LA) begin
                if (!en_hi) ns = P_LB;
            end else if (m_st == P_LB) begin
                if (en_hi) begin ns = P_HOLD; m_cnt = 0; end
            end else if (m_st == P_HOLD) begin
                if (m_cnt == RTY - 1) ns = P_RW;
                else m_cnt++;
            end else if (m_st == P_RW) begin
                if (go) begin ns = P_DLY; m_idx = 0; m_cnt = 0; end
            end else if (m_st == P_SD) begin
                if (pla) ns = P_IDLE;
            end
            if (flt) begin ns = m_rty ? P_HOLD : P_LA; m_cnt = 0; end
            if (!vint_ok && m_st != P_IDLE && m_st != P_SD) ns = P_SD;
            m_st = ns;
            sy2 = sy1;
            sy1 = {mode_pin, retry_pin};
        end
    end

    function automatic logic [8:0] model_out();
        logic [2:0] g, p;
        logic       fn, pgd;
        logic [1:0] rc;
        for (int i = 0; i < 3; i++) begin
            g[i] = rail_present[i] && ((m_st == P_UP) || (m_st == P_PGW) || (m_st == P_ON) ||
                   (m_st == P_DN) || (((m_st == P_DLY) || (m_st == P_SON)) &&
                   ((i < m_idx) || ((m_st == P_SON) && (i == m_idx)))));
            p[i] = rail_present[i] && ((m_st == P_LA) || (m_st == P_LB) || (m_st == P_HOLD) ||
                   (m_st == P_RW) || (m_st == P_SD));
        end
        fn  = !((m_st == P_LA) || (m_st == P_LB) || (m_st == P_HOLD) || (m_st == P_RW));
        rc  = ((m_st == P_UP) || (m_st == P_SON)) ? 2'b01 : ((m_st == P_DN) ? 2'b10 : 2'b00);
        pgd = (m_st == P_ON);
        return {g, p, fn, rc, pgd};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // compare with the model away from the clock edge, every cycle
    always begin
        @(posedge clk);
        #2;
        if (rst_n && !done) begin
            logic [8:0] act, exp;
            act = {gate_en, pd_en, fault_n, ramp_cmd, pwr_good};
            exp = model_out();
            chk(act == exp, {cur_req, " model"}, int'(act), int'(exp));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_gate(input logic [2:0] v, input string tag);
        int k = 0;
        while (gate_en !== v && k < 5000) begin @(negedge clk); k++; end
        chk(gate_en === v, tag, int'(gate_en), int'(v));
    endtask

    task automatic wait_pgood(input string tag);
        int k = 0;
        while (pwr_good !== 1'b1 && k < 5000) begin @(negedge clk); k++; end
        chk(pwr_good === 1'b1, tag, int'(pwr_good), 1);
    endtask

    initial begin
        int k;
        tick(5);
        // R1: reset state
        chk({gate_en, pd_en, fault_n, ramp_cmd, pwr_good} == 9'b000_000_1_00_0,
            "R1 reset", int'({gate_en, pd_en, fault_n, ramp_cmd, pwr_good}), 8);
        rst_n = 1'b1;
        tick(2);
        chk(gate_en == 3'b000 && fault_n, "R1 idle", int'(gate_en), 0);

        // R2/R3/R5/R6: tracked bring-up and common ramp-down
        cur_req = "R3";
        uvlo_ok = 3'b111; vint_ok = 1'b1;
        tick(4);
        en_hi = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (gate_en == 3'b000 && k < 100);
        chk(k == DLY + 1, "R2 start delay", k, DLY + 1);
        chk(gate_en == 3'b111 && ramp_cmd == 2'b01, "R3 all gates up", int'(gate_en), 7);
        out_pl = 3'b000;
        tick(3);
        out_pg = 3'b111;
        cur_req = "R5";
        k = 0;
        do begin @(negedge clk); k++; end while (!pwr_good && k < 100);
        chk(k == PGTO + 1, "R5 power-good timeout", k, PGTO + 1);
        tick(5);
        cur_req = "R6";
        en_hi = 1'b0;
        tick(1);
        chk(ramp_cmd == 2'b10 && gate_en == 3'b111 && pd_en == 3'b000, "R6 ramp down",
            int'(ramp_cmd), 2);
        out_pg = 3'b000;
        tick(3);
        out_pl = 3'b111;
        tick(1);
        chk(gate_en == 3'b000 && ramp_cmd == 2'b00 && pd_en == 3'b000, "R6 down done",
            int'(gate_en), 0);

        // R2: start condition lost during the delay
        cur_req = "R2";
        tick(3);
        en_hi = 1'b1;
        tick(2);
        en_hi = 1'b0;
        k = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (gate_en != 3'b000) k++; end
        chk(k == 0, "R2 aborted delay no gate", k, 0);

        // R4: sequential bring-up
        cur_req = "R4";
        mode_pin = 1'b1;
        tick(4);
        en_hi = 1'b1;
        wait_gate(3'b001, "R4 rail1 first");
        tick(2);
        out_pl[0] = 1'b0; out_pg[0] = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (gate_en != 3'b011 && k < 100);
        chk(k == DLY + 1, "R4 rail2 delay", k, DLY + 1);
        tick(2);
        out_pl[1] = 1'b0; out_pg[1] = 1'b1;
        wait_gate(3'b111, "R4 rail3 last");
        tick(2);
        out_pl[2] = 1'b0; out_pg[2] = 1'b1;
        wait_pgood("R4 sequence complete");
        en_hi = 1'b0;
        tick(2);
        out_pg = 3'b000; out_pl = 3'b111;
        wait_gate(3'b000, "R6 sequence ramp down");

        // R8/R9: tracking error, autoretry
        cur_req = "R8";
        mode_pin = 1'b0;
        tick(4);
        en_hi = 1'b1;
        wait_gate(3'b111, "R8 gates up");
        out_pl = 3'b000;
        tick(3);
        trk_fault = 1'b1;
        tick(1);
        trk_fault = 1'b0;
        chk(!fault_n && gate_en == 3'b000 && pd_en == 3'b111, "R8 tracking fault",
            int'({fault_n, pd_en}), 7);
        out_pl = 3'b111;
        cur_req = "R9";
        k = 0;
        while (!fault_n && k < 2000) begin @(negedge clk); k++; end
        chk(k == RTY + 1, "R9 retry hold", k, RTY + 1);
        wait_gate(3'b111, "R9 retry bring-up");

        // R8: bring-up timeout
        cur_req = "R8";
        out_pl = 3'b000;
        k = 0;
        while (fault_n && k < 200) begin @(negedge clk); k++; end
        chk(k == FLT, "R8 bring-up timeout", k, FLT);
        out_pl = 3'b111;

        // R13: pins changed during the hold are ignored
        cur_req = "R13";
        retry_pin = 1'b0; mode_pin = 1'b1;
        k = 0;
        while (!fault_n && k < 2000) begin @(negedge clk); k++; end
        chk(fault_n == 1'b1, "R13 retry pin ignored", int'(fault_n), 1);
        wait_gate(3'b111, "R13 mode pin ignored");

        // R11: internal supply loss
        cur_req = "R11";
        out_pl = 3'b000;
        tick(2);
        vint_ok = 1'b0;
        tick(1);
        chk(gate_en == 3'b000 && pd_en == 3'b111 && fault_n, "R11 supply loss",
            int'({gate_en, pd_en}), 7);
        mode_pin = 1'b0;
        tick(3);
        out_pl = 3'b111;
        tick(2);
        chk(pd_en == 3'b000, "R11 back to idle", int'(pd_en), 0);

        // R10: latch-off mode
        cur_req = "R10";
        vint_ok = 1'b1;
        wait_gate(3'b111, "R10 gates up");
        tick(2);
        trk_fault = 1'b1;
        tick(1);
        trk_fault = 1'b0;
        tick(600);
        chk(!fault_n, "R10 latched", int'(fault_n), 0);
        en_hi = 1'b0;
        tick(3);
        chk(!fault_n, "R10 enable low still latched", int'(fault_n), 0);
        en_hi = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (!fault_n && k < 2000);
        chk(k == RTY + 2, "R10 release after enable cycle", k, RTY + 2);
        wait_gate(3'b111, "R10 new attempt");

        // R7: enable lost before power good
        cur_req = "R7";
        en_hi = 1'b0;
        out_pl = 3'b000;
        tick(1);
        chk(gate_en == 3'b000 && pd_en == 3'b111 && fault_n, "R7 fast shutdown",
            int'({gate_en, pd_en, fault_n}), 15);
        tick(3);
        out_pl = 3'b111;
        tick(3);

        // R12: excluded middle rail, sequence mode
        cur_req = "R12";
        rail_present = 3'b101;
        mode_pin = 1'b1;
        out_pl = 3'b101;
        out_pg = 3'b000;
        tick(4);
        en_hi = 1'b1;
        wait_gate(3'b001, "R12 rail1");
        out_pl[0] = 1'b0; out_pg[0] = 1'b1;
        wait_gate(3'b101, "R12 middle skipped");
        tick(2);
        out_pl[2] = 1'b0; out_pg[2] = 1'b1;
        wait_pgood("R12 power good");
        chk(gate_en == 3'b101, "R12 excluded gate off", int'(gate_en), 5);

        tick(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule